// File: doc/BRIEF.md
# Reset Pin Glitch Detector

This block sits behind the input synchronizer of the external reset pad and sorts each low period on that pad into one of three bins. A very short low (one or two clock cycles) is dropped as noise. A low that lasts beyond the short threshold but ends before the long threshold counts as a glitch and sets a sticky glitch flag in a status register. A low held for the full long threshold is a genuine reset request. It produces a one-cycle pulse that starts the chip's reset sequence.

Two counts set the two thresholds: a short arming count and a long qualifying count. Once the low run passes the arming count, an internal arm latch is set. If the pad goes high while the latch is set, the glitch flag is set. Setting the flag touches no other status bit. Software clears the flag by writing a one to it, and a genuine reset also clears it. While the reset sequencer reports that a reset cycle is already under way, the pad is ignored.

Top module: `rstpin_glitch_det`

## Requirements
- R1: During and directly after the synchronous block reset (`rst_n` low), `valid_rst_o` and `glitch_flag_o` are both 0.
- R2: A pad low run of 1 or 2 sampled cycles, followed by a high sample, leaves `glitch_flag_o` unchanged and produces no `valid_rst_o` pulse.
- R3: A low run of 3 to 9 sampled cycles (longer than ARM_CYCLES=2, shorter than VALID_CYCLES=10), followed by a high sample, sets `glitch_flag_o` at the clock edge that samples the pad high. No `valid_rst_o` pulse is produced.
- R4: A low run that reaches 10 sampled cycles drives `valid_rst_o` high for exactly one cycle, registered at the 10th low edge. Holding the pad low longer produces no further pulse.
- R5: A genuine reset (R4) clears `glitch_flag_o` at the same edge that raises `valid_rst_o`.
- R6: Once set, `glitch_flag_o` stays 1 through idle cycles and further short runs until it is cleared as in R5 or R7.
- R7: `flag_clr_i`=1 at a clock edge clears `glitch_flag_o` at that edge.
- R8: If a glitch sets the flag at the same edge where `flag_clr_i`=1, the flag ends up 1.
- R9: While `rst_busy_i`=1, pad lows are ignored and the low-run count restarts from zero. A genuine reset needs 10 low samples taken while `rst_busy_i`=0.
- R10: A recorded glitch clears the arm latch. After the flag is cleared, a following 1- or 2-cycle run does not set the flag again.
- R11: If `rst_busy_i` rises during an armed low run, the arm latch is cleared. A later release then does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pad_rst_n_i | input | 1 | Synchronized reset pad level, active low |
| flag_clr_i | input | 1 | Software write-one-to-clear strobe for the glitch flag |
| rst_busy_i | input | 1 | High while a reset cycle is already being processed |
| valid_rst_o | output | 1 | One-cycle pulse marking a genuine reset request |
| glitch_flag_o | output | 1 | Sticky glitch status bit |

## Verification
The checker keeps its own count of the current low run. On every cycle it checks five things: that a genuine-reset pulse lasts one cycle and comes only when that count hits the long threshold, that the flag rises only on a release after a run strictly between the two thresholds, that the flag falls only through a clear strobe or a genuine reset, and that a busy cycle is never followed by a pulse or a new flag. Some behaviours can only be shown by the bench's scenarios, because they depend on a history across several runs: a set winning over a simultaneous clear, the arm latch being dropped after a glitch or by a busy period, and a count restarting once busy ends. Random runs of mixed lengths, with random busy and clear stimulus, are compared against a run-level expectation function.

// File: rtl/rgd_pkg.sv
// Package: shared helpers for the reset pad glitch detector.
// Assumes: counts passed in are positive.
package rgd_pkg;
    // Width needed to hold values 0..max_val.
    function automatic int count_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/rgd_run_counter.sv
// Module: rgd_run_counter
// Counts consecutive qualified low samples of the reset pad and saturates
// at MAX_COUNT. Any cycle without a qualified low returns the count to zero.
// Assumes: count_en is already qualified (pad low and no reset in progress).
module rgd_run_counter #(
    parameter int MAX_COUNT = 10,
    localparam int W = rgd_pkg::count_width(MAX_COUNT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] LIMIT = W'(MAX_COUNT);

    logic [W-1:0] count_q;

    // Purpose: advance the saturating low-run count, or restart it on any break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!count_en) begin
            count_q <= '0;
        end else if (count_q != LIMIT) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/rgd_arm_latch.sv
// Module: rgd_arm_latch
// Holds the "short threshold passed" condition for the current low run.
// Clear has priority over set.
// Assumes: set_i and clr_i are single-cycle qualified events.
module rgd_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic armed_o
);
    logic armed_q;

    // Purpose: keep the arm state, dropping it whenever any clear source fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr_i) begin
            armed_q <= 1'b0;
        end else if (set_i) begin
            armed_q <= 1'b1;
        end
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/rgd_status_flag.sv
// Module: rgd_status_flag
// Sticky status bit. A hardware set beats any clear that arrives in the same cycle.
// Assumes: sw_clr_i is a one-cycle write-one strobe; hw_clr_i is a one-cycle event.
module rgd_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic sw_clr_i,
    input  logic hw_clr_i,
    output logic flag_o
);
    logic flag_q;

    // Purpose: update the sticky bit, with set taking priority over both clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hw_set_i) begin
            flag_q <= 1'b1;
        end else if (sw_clr_i || hw_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rstpin_glitch_det.sv
// Module: rstpin_glitch_det
// Sorts each low period of the synchronized reset pad into noise, glitch or
// genuine reset, using a short arming count and a long qualifying count.
// Assumes: pad_rst_n_i is already synchronized to clk; rst_busy_i comes from
// the reset sequencer and is high for the whole reset cycle.
module rstpin_glitch_det #(
    parameter int ARM_CYCLES   = 2,
    parameter int VALID_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_rst_n_i,
    input  logic flag_clr_i,
    input  logic rst_busy_i,
    output logic valid_rst_o,
    output logic glitch_flag_o
);
    localparam int W = rgd_pkg::count_width(VALID_CYCLES);
    localparam logic [W-1:0] ARM_AT   = W'(ARM_CYCLES);
    localparam logic [W-1:0] VALID_AT = W'(VALID_CYCLES - 1);

    logic         low_ok;
    logic [W-1:0] run_count;
    logic         armed;
    logic         arm_set;
    logic         arm_clr;
    logic         glitch_hit;
    logic         valid_hit;
    logic         valid_q;

    // Purpose: qualify a pad low sample; nothing counts during a reset cycle.
    always_comb begin
        low_ok = !pad_rst_n_i && !rst_busy_i;
    end

    rgd_run_counter #(
        .MAX_COUNT (VALID_CYCLES)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (low_ok),
        .count_o  (run_count)
    );

    // Purpose: decode the threshold events from the run count and pad state.
    always_comb begin
        arm_set    = low_ok && (run_count == ARM_AT);
        valid_hit  = low_ok && (run_count == VALID_AT);
        glitch_hit = armed && pad_rst_n_i && !rst_busy_i;
        arm_clr    = glitch_hit || valid_hit || rst_busy_i;
    end

    rgd_arm_latch u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (arm_set),
        .clr_i   (arm_clr),
        .armed_o (armed)
    );

    rgd_status_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set_i (glitch_hit),
        .sw_clr_i (flag_clr_i),
        .hw_clr_i (valid_hit),
        .flag_o   (glitch_flag_o)
    );

    // Purpose: register the genuine-reset event as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_hit;
        end
    end

    assign valid_rst_o = valid_q;
endmodule

// File: rtl/rstpin_glitch_det_chk.sv
// Module: rstpin_glitch_det_chk
// Property checker for rstpin_glitch_det. It keeps its own low-run count,
// built from the ports only, and is bound to every instance of the top.
module rstpin_glitch_det_chk #(
    parameter int ARM_CYCLES   = 2,
    parameter int VALID_CYCLES = 10
) (
    input logic clk,
    input logic rst_n,
    input logic pad_rst_n_i,
    input logic flag_clr_i,
    input logic rst_busy_i,
    input logic valid_rst_o,
    input logic glitch_flag_o
);
    int run_q;

    // Purpose: count qualified low samples independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (pad_rst_n_i || rst_busy_i) begin
            run_q <= 0;
        end else if (run_q < VALID_CYCLES) begin
            run_q <= run_q + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !valid_rst_o && !glitch_flag_o); // R1
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) valid_rst_o |=> !valid_rst_o); // R4
    AST_VALID_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) valid_rst_o |-> run_q == VALID_CYCLES); // R4
    AST_GLITCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glitch_flag_o) |-> $past(pad_rst_n_i) && $past(run_q) > ARM_CYCLES && $past(run_q) < VALID_CYCLES); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glitch_flag_o) |-> $past(flag_clr_i) || valid_rst_o); // R6
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy_i |=> !valid_rst_o && !$rose(glitch_flag_o)); // R9
endmodule

bind rstpin_glitch_det rstpin_glitch_det_chk #(
    .ARM_CYCLES   (ARM_CYCLES),
    .VALID_CYCLES (VALID_CYCLES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pad_rst_n_i   (pad_rst_n_i),
    .flag_clr_i    (flag_clr_i),
    .rst_busy_i    (rst_busy_i),
    .valid_rst_o   (valid_rst_o),
    .glitch_flag_o (glitch_flag_o)
);

// File: tb/test_rstpin_glitch_det.sv
module test_rstpin_glitch_det;
    localparam int ARM   = 2;
    localparam int VALID = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pad_n = 1'b1;
    logic clr = 1'b0;
    logic busy = 1'b0;
    logic valid;
    logic flag;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstpin_glitch_det #(.ARM_CYCLES(ARM), .VALID_CYCLES(VALID)) i_rstpin_glitch_det (
        .clk(clk), .rst_n(rst_n), .pad_rst_n_i(pad_n), .flag_clr_i(clr),
        .rst_busy_i(busy), .valid_rst_o(valid), .glitch_flag_o(flag)
    );

    // Count every cycle with the genuine-reset pulse high, shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && valid) pulses++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected flag after one low run, computed from the requirements.
    function automatic bit flag_after(input bit prev, input int len, input bit bsy);
        if (bsy) return prev;
        if (len >= VALID) return 1'b0;
        if (len > ARM) return 1'b1;
        return prev;
    endfunction

    function automatic int pulses_for(input int len, input bit bsy);
        return (!bsy && len >= VALID) ? 1 : 0;
    endfunction

    // Drive a low run of len cycles, then release; state is sampled one cycle after release.
    task automatic low_run(input int len, input bit bsy, input bit clr_at_release);
        @(negedge clk);
        pad_n = (len == 0); busy = bsy;
        repeat (len) @(negedge clk);
        pad_n = 1'b1; busy = 1'b0; clr = clr_at_release;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_flag = 1'b0;
    endtask

    initial begin
        int p0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", valid, 0);
        check("R1 flag in reset", flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", valid, 0);
        check("R1 flag after reset", flag, 0);

        for (int l = 1; l <= 2; l++) begin
            p0 = pulses; low_run(l, 0, 0);
            check("R2 short run flag", flag, 0);
            check("R2 short run pulse", pulses - p0, 0);
        end

        p0 = pulses; low_run(3, 0, 0); exp_flag = 1'b1;
        check("R3 run of 3 sets flag", flag, 1);
        check("R3 run of 3 no pulse", pulses - p0, 0);
        low_run(2, 0, 0);
        check("R6 flag held after short run", flag, 1);
        repeat (5) @(negedge clk);
        check("R6 flag held idle", flag, 1);
        sw_clear();
        check("R7 software clear", flag, 0);

        p0 = pulses; low_run(9, 0, 0); exp_flag = 1'b1;
        check("R3 run of 9 sets flag", flag, 1);
        check("R3 run of 9 no pulse", pulses - p0, 0);
        sw_clear();
        low_run(2, 0, 0);
        check("R10 latch dropped after glitch", flag, 0);

        // Long hold: pulse exactly after 10th low edge, one cycle only, flag cleared.
        low_run(4, 0, 0);
        check("R3 flag before long run", flag, 1);
        p0 = pulses;
        @(negedge clk); pad_n = 1'b0;
        repeat (9) @(negedge clk);
        check("R4 no pulse at 9", pulses - p0, 0);
        @(negedge clk);
        check("R4 pulse at 10", valid, 1);
        check("R5 flag cleared by genuine reset", flag, 0);
        repeat (6) @(negedge clk);
        check("R4 single pulse while held", pulses - p0, 1);
        pad_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 no flag after genuine reset", flag, 0);
        exp_flag = 1'b0;

        low_run(5, 0, 1);
        check("R8 set wins over clear", flag, 1);
        exp_flag = 1'b1;
        sw_clear();

        // Busy rises mid-run after arming: release must not set the flag.
        @(negedge clk); pad_n = 1'b0;
        repeat (5) @(negedge clk);
        busy = 1'b1;
        repeat (2) @(negedge clk);
        busy = 1'b0; pad_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 busy drops arm latch", flag, 0);

        // Busy during long low, then count restarts once busy ends.
        p0 = pulses;
        @(negedge clk); pad_n = 1'b0; busy = 1'b1;
        repeat (12) @(negedge clk);
        check("R9 no pulse while busy", pulses - p0, 0);
        busy = 1'b0;
        repeat (9) @(negedge clk);
        check("R9 count restarts after busy", pulses - p0, 0);
        @(negedge clk);
        check("R9 pulse after 10 unbusy lows", pulses - p0, 1);
        pad_n = 1'b1;
        repeat (2) @(negedge clk);

        // Random runs against the run-level expectation.
        for (int i = 0; i < 60; i++) begin
            int len = $urandom_range(0, 13);
            bit bsy = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 3) == 0) sw_clear();
            p0 = pulses;
            low_run(len, bsy, 0);
            exp_flag = flag_after(exp_flag, len, bsy);
            check(bsy ? "R9 random busy flag" : (len >= VALID ? "R5 random flag" : "R3 random flag"),
                  flag, exp_flag);
            check(len >= VALID ? "R4 random pulses" : "R2 random pulses", pulses - p0, pulses_for(len, bsy));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule